// File: doc/BRIEF.md
# NAND Flash Register-Driven Bus Sequencer

This block sits between a simple host register port and a raw 8-bit NAND flash bus. Software issues commands, addresses and data as ordinary register writes and reads. Each such access becomes one NAND bus beat or a burst of four beats. A command beat is qualified by CLE and an address beat by ALE. Data beats move bytes out of, or into, a 32-bit host word. The block samples the device's ready/busy line and returns it as a status bit. It never waits on that line by itself: polling is left to software.

Every strobe phase has a programmable cycle count. These are the signal setup time before a strobe, the write-pulse and read-pulse low and high times, the hold time after a strobe, the delay after a command before busy may be sampled, and the time chip enable stays released after a sequence. A one-hot bank register picks which chip-enable output is used. A per-access release flag decides whether chip enable is dropped when the sequence ends.

Writes to the command, address and data registers are posted: the host gets its acknowledge at once and the beats run behind it. A data read is acknowledged only once its bytes have arrived. Any host access that arrives while beats are still running is held off until the sequence has finished.

Top module: `nand_flex_seq`

Register indices on `host_addr`: 0 mode, 1 control timing, 2 write-strobe timing, 3 read-strobe timing, 4 bank select, 5 status, 6 command, 7 address, 8 data, 9 read-data config, 10 write-data config.

## Requirements
- R1: A host write to the command register (index 6) produces exactly one write beat: WEn pulses low once, CLE is high, ALE is low, and the bus carries bits [7:0] of the written word.
- R2: A host write to the address register (index 7) with bit 30 set produces one write beat with ALE high, CLE low and bits [7:0] on the bus. With bit 30 clear, no beat is produced.
- R3: A write to the data register (index 8) produces one beat carrying bits [7:0] when bit 28 of the write-data config (index 10) is 0. When that bit is 1 it produces four beats, in the order bits [7:0], [15:8], [23:16], [31:24].
- R4: A read of the data register returns one device byte in bits [7:0], with the upper bits zero, when bit 28 of the read-data config (index 9) is 0. When that bit is 1 it returns four bytes, with the first byte read in [7:0] and the last in [31:24].
- R5: Each strobe phase lasts its programmed count, and a count of 0 acts as 1. WEn stays low for the write-timing field [7:0]. REn stays low for the read-timing field [7:0]. Between consecutive beats of a burst, the write strobe stays high for write-timing [15:8] plus control-timing hold [15:8] plus setup [7:0].
- R6: The bank register (index 4, reset value 1) accepts only one-hot values and ignores any other write. During beats, chip-enable output k is low exactly when bit k of the bank register is set. At most one chip enable is ever low.
- R7: Bit 2 of the status register (index 5) reads as the ready/busy input (1 = ready) once the input has been stable for three clock cycles.
- R8: Mode register (index 0) bit 0 enables the bus engine. While it is 0, command, address and data writes produce no beats. Setting bit 3 returns every other register to its reset value, and holds them there until bit 3 is cleared.
- R9: Bit 31 of a command or address word, and of the data config words, releases all chip enables (high) at the end of the sequence. When that bit is 0, the selected chip enable stays low after the sequence.
- R10: A host access that arrives while a beat sequence is running is not acknowledged until the sequence, including its trailing delays, has finished. WEn and REn are never low together, and CLE and ALE are never high together.
- R11: The timing registers read back as written. Control timing (index 1) holds setup [7:0], hold [15:8], chip-enable release time [23:16] and command-to-busy delay [31:24]. The strobe timing registers (indices 2 and 3) hold the low time in [7:0] and the high time in [15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Register index |
| host_wdata | input | 32 | Write data |
| host_ack | output | 1 | One-cycle acknowledge of the access |
| host_rdata | output | 32 | Read data, valid with host_ack |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | NBANK | Chip enables, active low, one per bank |
| nand_dq_o | output | 8 | Bus data out |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus data in |
| nand_rb_n | input | 1 | Device ready/busy, 1 = ready |

## Verification
The bench goes after byte order in four-beat bursts. A design that swapped lanes would send or assemble words back to front. It also programs strobe counts of zero, which a naive counter would turn into 256-cycle pulses, and it checks the inter-beat gap that sums three phases. It writes non-one-hot bank values, which a careless register would store and use to assert two chip enables at once. It also issues address writes without the valid flag, which should produce no beat. Finally it issues an access right behind a posted command and measures its acknowledge latency. A design that failed to stall would acknowledge before the command-to-busy and chip-enable release delays had run out.

// File: rtl/nand_flex_pkg.sv
package nand_flex_pkg;
   localparam int HW  = 32;
   localparam int RAW = 4;

   localparam int B_MODE_EN  = 0;
   localparam int B_MODE_RST = 3;
   localparam int B_STAT_RDY = 2;
   localparam int B_QUAD     = 28;
   localparam int B_ADDR_OK  = 30;
   localparam int B_REL      = 31;

   typedef enum logic [RAW-1:0] {
      RG_MODE = 4'd0, RG_CTIM = 4'd1, RG_WTIM = 4'd2, RG_RTIM = 4'd3,
      RG_BANK = 4'd4, RG_STAT = 4'd5, RG_CMD  = 4'd6, RG_ADDR = 4'd7,
      RG_DATA = 4'd8, RG_RCFG = 4'd9, RG_WCFG = 4'd10
   } reg_e;

   typedef enum logic [1:0] {K_CMD, K_ADDR, K_WDAT, K_RDAT} kind_e;

   typedef enum logic [2:0] {
      S_IDLE, S_SETUP, S_PULSE, S_RECOV, S_HOLD, S_TWB, S_CEOFF
   } st_e;

   typedef struct packed {
      logic [7:0] twb;
      logic [7:0] ceoff;
      logic [7:0] hold;
      logic [7:0] setup;
   } ctim_t;

   typedef struct packed {
      logic [7:0] off;
      logic [7:0] on;
   } stb_t;
endpackage

// File: rtl/nand_flex_sync.sv
module nand_flex_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $fatal(1, "nand_flex_sync needs at least two stages");
   end

   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d};
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/nand_flex_regs.sv
module nand_flex_regs
   import nand_flex_pkg::*;
#(
   parameter int NBANK = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  reg_e             waddr,
   input  logic [HW-1:0]    wdata,
   input  reg_e             raddr,
   input  logic             rdy,
   output logic [HW-1:0]    rdata,
   output logic             mode_en,
   output logic             soft_rst,
   output ctim_t            ctim,
   output stb_t             wtim,
   output stb_t             rtim,
   output logic [NBANK-1:0] bank,
   output logic             rd_quad,
   output logic             rd_rel,
   output logic             wr_quad,
   output logic             wr_rel
);
   if (NBANK < 1 || NBANK > HW) begin : g_bad_nbank
      $fatal(1, "NBANK must lie between 1 and the host word width");
   end

   localparam logic [NBANK-1:0] BANK_RST = NBANK'(1);

   logic bank_ok;
   assign bank_ok = $onehot(wdata) && ((wdata >> NBANK) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_en  <= 1'b0;
         soft_rst <= 1'b0;
      end else if (wr_en && waddr == RG_MODE) begin
         mode_en  <= wdata[B_MODE_EN];
         soft_rst <= wdata[B_MODE_RST];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctim <= '0; wtim <= '0; rtim <= '0; bank <= BANK_RST;
         rd_quad <= 1'b0; rd_rel <= 1'b1; wr_quad <= 1'b0; wr_rel <= 1'b1;
      end else if (soft_rst) begin
         ctim <= '0; wtim <= '0; rtim <= '0; bank <= BANK_RST;
         rd_quad <= 1'b0; rd_rel <= 1'b1; wr_quad <= 1'b0; wr_rel <= 1'b1;
      end else if (wr_en) begin
         case (waddr)
            RG_CTIM: ctim <= wdata;
            RG_WTIM: wtim <= wdata[15:0];
            RG_RTIM: rtim <= wdata[15:0];
            RG_BANK: if (bank_ok) bank <= wdata[NBANK-1:0];
            RG_RCFG: begin rd_quad <= wdata[B_QUAD]; rd_rel <= wdata[B_REL]; end
            RG_WCFG: begin wr_quad <= wdata[B_QUAD]; wr_rel <= wdata[B_REL]; end
            default: ;
         endcase
      end
   end

   logic [HW-1:0] bank_ext;
   always_comb begin
      bank_ext = '0;
      bank_ext[NBANK-1:0] = bank;
   end

   always_comb begin
      rdata = '0;
      case (raddr)
         RG_MODE: begin rdata[B_MODE_EN] = mode_en; rdata[B_MODE_RST] = soft_rst; end
         RG_CTIM: rdata = ctim;
         RG_WTIM: rdata[15:0] = wtim;
         RG_RTIM: rdata[15:0] = rtim;
         RG_BANK: rdata = bank_ext;
         RG_STAT: rdata[B_STAT_RDY] = rdy;
         RG_RCFG: begin rdata[B_QUAD] = rd_quad; rdata[B_REL] = rd_rel; end
         RG_WCFG: begin rdata[B_QUAD] = wr_quad; rdata[B_REL] = wr_rel; end
         default: rdata = '0;
      endcase
   end

   AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(bank)); // R6
endmodule

// File: rtl/nand_flex_engine.sv
module nand_flex_engine
   import nand_flex_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          start,
   input  kind_e         kind,
   input  logic [HW-1:0] wword,
   input  logic          quad,
   input  logic          rel,
   input  ctim_t         ctim,
   input  stb_t          wtim,
   input  stb_t          rtim,
   input  logic [7:0]    dq_i,
   output logic          busy,
   output logic          done,
   output logic [HW-1:0] rword,
   output logic          cle,
   output logic          ale,
   output logic          we_n,
   output logic          re_n,
   output logic          ce_act,
   output logic [7:0]    dq_o,
   output logic          dq_oe
);
   localparam int BEATS_W = $clog2(HW / 8);
   localparam logic [BEATS_W-1:0] LAST_QUAD = BEATS_W'(HW / 8 - 1);

   st_e               st;
   kind_e             kind_q;
   logic [7:0]        cnt, plen;
   logic [BEATS_W-1:0] beat, last;
   logic              rel_q, ce_hold;
   logic [HW-1:0]     word_q;
   logic              is_rd, in_beat, pend;

   assign is_rd   = (kind_q == K_RDAT);
   assign in_beat = (st == S_SETUP) || (st == S_PULSE) || (st == S_RECOV) || (st == S_HOLD);

   always_comb begin
      case (st)
         S_SETUP: plen = ctim.setup;
         S_PULSE: plen = is_rd ? rtim.on  : wtim.on;
         S_RECOV: plen = is_rd ? rtim.off : wtim.off;
         S_HOLD:  plen = ctim.hold;
         S_TWB:   plen = ctim.twb;
         S_CEOFF: plen = ctim.ceoff;
         default: plen = 8'd0;
      endcase
   end
   assign pend = (cnt >= plen);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE; kind_q <= K_CMD; cnt <= 8'd1; beat <= '0; last <= '0;
         rel_q <= 1'b0; ce_hold <= 1'b0; word_q <= '0; done <= 1'b0;
      end else if (soft_rst) begin
         st <= S_IDLE; kind_q <= K_CMD; cnt <= 8'd1; beat <= '0; last <= '0;
         rel_q <= 1'b0; ce_hold <= 1'b0; word_q <= '0; done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (st == S_IDLE) begin
            if (start) begin
               st      <= S_SETUP;
               cnt     <= 8'd1;
               beat    <= '0;
               last    <= (quad && (kind == K_WDAT || kind == K_RDAT)) ? LAST_QUAD : '0;
               kind_q  <= kind;
               rel_q   <= rel;
               word_q  <= (kind == K_RDAT) ? '0 : wword;
               ce_hold <= 1'b1;
            end
         end else if (pend) begin
            cnt <= 8'd1;
            case (st)
               S_SETUP: st <= S_PULSE;
               S_PULSE: begin
                  st <= S_RECOV;
                  if (is_rd) word_q[{beat, 3'b000} +: 8] <= dq_i;
               end
               S_RECOV: st <= S_HOLD;
               S_HOLD: begin
                  if (beat != last) begin
                     beat <= beat + 1'b1;
                     st   <= S_SETUP;
                  end else if (kind_q == K_CMD) begin
                     st <= S_TWB;
                  end else if (rel_q) begin
                     st <= S_CEOFF; ce_hold <= 1'b0;
                  end else begin
                     st <= S_IDLE; done <= 1'b1;
                  end
               end
               S_TWB: begin
                  if (rel_q) begin st <= S_CEOFF; ce_hold <= 1'b0; end
                  else begin st <= S_IDLE; done <= 1'b1; end
               end
               S_CEOFF: begin st <= S_IDLE; done <= 1'b1; end
               default: st <= S_IDLE;
            endcase
         end else begin
            cnt <= cnt + 8'd1;
         end
      end
   end

   assign busy   = (st != S_IDLE);
   assign rword  = word_q;
   assign cle    = in_beat && (kind_q == K_CMD);
   assign ale    = in_beat && (kind_q == K_ADDR);
   assign we_n   = !(st == S_PULSE && !is_rd);
   assign re_n   = !(st == S_PULSE && is_rd);
   assign ce_act = ce_hold;
   assign dq_o   = word_q[{beat, 3'b000} +: 8];
   assign dq_oe  = in_beat && !is_rd;

   AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !re_n |-> !dq_oe); // R4
   AST_WE_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n && $past(!we_n)) |-> $stable(dq_o)); // R3
   AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n || !re_n) |-> ce_act); // R9
endmodule

// File: rtl/nand_flex_seq.sv
module nand_flex_seq
   import nand_flex_pkg::*;
#(
   parameter int NBANK       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_req,
   input  logic             host_wr,
   input  logic [RAW-1:0]   host_addr,
   input  logic [HW-1:0]    host_wdata,
   output logic             host_ack,
   output logic [HW-1:0]    host_rdata,
   output logic             nand_cle,
   output logic             nand_ale,
   output logic             nand_we_n,
   output logic             nand_re_n,
   output logic [NBANK-1:0] nand_ce_n,
   output logic [7:0]       nand_dq_o,
   output logic             nand_dq_oe,
   input  logic [7:0]       nand_dq_i,
   input  logic             nand_rb_n
);
   reg_e          ra;
   logic          accept, ack_q, rd_wait;
   logic          is_cmd, is_adr, is_wd, is_rd, seq, eng_start;
   logic          eng_busy, eng_done, ce_act, rdy;
   logic [HW-1:0] reg_rdata, eng_rword, rdata_q;
   logic          mode_en, soft_rst, rd_quad, rd_rel, wr_quad, wr_rel;
   logic          st_quad, st_rel;
   kind_e         st_kind;
   ctim_t         ctim;
   stb_t          wtim, rtim;
   logic [NBANK-1:0] bank;

   assign ra     = reg_e'(host_addr);
   assign accept = host_req && !ack_q && !eng_busy && !rd_wait;
   assign is_cmd = host_wr && ra == RG_CMD;
   assign is_adr = host_wr && ra == RG_ADDR && host_wdata[B_ADDR_OK];
   assign is_wd  = host_wr && ra == RG_DATA;
   assign is_rd  = !host_wr && ra == RG_DATA;
   assign seq    = mode_en && !soft_rst && (is_cmd || is_adr || is_wd || is_rd);
   assign eng_start = accept && seq;

   always_comb begin
      if (is_cmd)      begin st_kind = K_CMD;  st_rel = host_wdata[B_REL]; st_quad = 1'b0;    end
      else if (is_adr) begin st_kind = K_ADDR; st_rel = host_wdata[B_REL]; st_quad = 1'b0;    end
      else if (is_wd)  begin st_kind = K_WDAT; st_rel = wr_rel;            st_quad = wr_quad; end
      else             begin st_kind = K_RDAT; st_rel = rd_rel;            st_quad = rd_quad; end
   end

   nand_flex_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(nand_rb_n), .q(rdy)
   );

   nand_flex_regs #(.NBANK(NBANK)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(accept && host_wr), .waddr(ra),
      .wdata(host_wdata), .raddr(ra), .rdy(rdy), .rdata(reg_rdata),
      .mode_en(mode_en), .soft_rst(soft_rst), .ctim(ctim), .wtim(wtim),
      .rtim(rtim), .bank(bank), .rd_quad(rd_quad), .rd_rel(rd_rel),
      .wr_quad(wr_quad), .wr_rel(wr_rel)
   );

   nand_flex_engine i_engine (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start(eng_start),
      .kind(st_kind), .wword(host_wdata), .quad(st_quad), .rel(st_rel),
      .ctim(ctim), .wtim(wtim), .rtim(rtim), .dq_i(nand_dq_i),
      .busy(eng_busy), .done(eng_done), .rword(eng_rword),
      .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
      .ce_act(ce_act), .dq_o(nand_dq_o), .dq_oe(nand_dq_oe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q   <= 1'b0;
         rd_wait <= 1'b0;
         rdata_q <= '0;
      end else begin
         ack_q <= (accept && !(eng_start && is_rd)) || (eng_done && rd_wait);
         if (eng_start && is_rd)      rd_wait <= 1'b1;
         else if (eng_done)           rd_wait <= 1'b0;
         if (accept && !host_wr)      rdata_q <= (ra == RG_DATA) ? '0 : reg_rdata;
         if (eng_done && rd_wait)     rdata_q <= eng_rword;
      end
   end

   assign host_ack   = ack_q;
   assign host_rdata = rdata_q;

   for (genvar g = 0; g < NBANK; g++) begin : g_ce
      assign nand_ce_n[g] = !(bank[g] && ce_act);
   end

   AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~nand_ce_n)); // R6
   AST_STALL_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_busy && $past(eng_busy)) |-> !host_ack); // R10
endmodule

// File: tb/test_nand_flex_seq.sv
module test_nand_flex_seq;
   localparam int NB = 4;
   localparam logic [3:0] A_MODE = 0, A_CTIM = 1, A_WTIM = 2, A_RTIM = 3, A_BANK = 4,
                          A_STAT = 5, A_CMD = 6, A_ADDR = 7, A_DATA = 8, A_RCFG = 9, A_WCFG = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic host_req = 1'b0, host_wr = 1'b0, host_ack;
   logic [3:0]  host_addr = '0;
   logic [31:0] host_wdata = '0, host_rdata;
   logic nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [NB-1:0] nand_ce_n;
   logic [7:0] nand_dq_o, nand_dq_i = 8'h00;
   logic nand_rb_n = 1'b1;

   always #4 clk = ~clk;

   nand_flex_seq #(.NBANK(NB)) i_nand_flex_seq (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
      .host_rdata(host_rdata), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_ce_n(nand_ce_n),
      .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
      .nand_rb_n(nand_rb_n)
   );

   int total = 0, bad = 0;

   // device model: write-beat log and read source
   logic [7:0]    lg_b   [256];
   logic          lg_cle [256];
   logic          lg_ale [256];
   int            lg_wlow[256];
   int            lg_gap [256];
   logic [NB-1:0] lg_ce  [256];
   int wr_n = 0, rd_n = 0, wl = 0, wh = 0, gap_now = 0, rl = 0, last_rlow = 0, excl_bad = 0;
   logic pw = 1'b1, pr = 1'b1, cs_cle = 1'b0, cs_ale = 1'b0;
   logic [7:0] cs_b = '0;
   logic [NB-1:0] cs_ce = '1;

   function automatic logic [7:0] rsrc(int i);
      return 8'((i * 53 + 167) & 255);
   endfunction

   function automatic int mx1(logic [7:0] v);
      return (v == 0) ? 1 : int'(v);
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         if (!nand_we_n && !nand_re_n) excl_bad++;
         if (nand_cle && nand_ale)     excl_bad++;
         if (!nand_we_n) begin
            if (pw) begin gap_now = wh; wh = 0; end
            wl++;
            cs_b = nand_dq_o; cs_cle = nand_cle; cs_ale = nand_ale; cs_ce = nand_ce_n;
         end else begin
            if (!pw) begin
               lg_b[wr_n % 256] = cs_b; lg_cle[wr_n % 256] = cs_cle; lg_ale[wr_n % 256] = cs_ale;
               lg_wlow[wr_n % 256] = wl; lg_gap[wr_n % 256] = gap_now; lg_ce[wr_n % 256] = cs_ce;
               wr_n++; wl = 0;
            end
            wh++;
         end
         if (!nand_re_n) begin
            if (pr) begin nand_dq_i = rsrc(rd_n); rd_n++; rl = 0; end
            rl++;
         end else if (!pr) begin
            last_rlow = rl;
         end
         pw = nand_we_n; pr = nand_re_n;
      end
   end

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic acc(input logic wr, input logic [3:0] a, input logic [31:0] d,
                      output logic [31:0] q, output int lat);
      @(negedge clk);
      host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d; lat = 0;
      do begin @(negedge clk); lat++; end while (!host_ack);
      q = host_rdata;
      host_req = 1'b0;
   endtask

   task automatic wreg(logic [3:0] a, logic [31:0] d);
      logic [31:0] q; int l;
      acc(1'b1, a, d, q, l);
   endtask

   task automatic rreg(logic [3:0] a, output logic [31:0] q);
      int l;
      acc(1'b0, a, 32'h0, q, l);
   endtask

   task automatic barrier;
      logic [31:0] q;
      rreg(A_MODE, q);
   endtask

   initial begin
      #(8 * 150000);
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] q, w, exp;
      logic [7:0] b, su, ho, ce, tw, won, wof, ron, rof;
      int n0, r0, lat, gap;
      void'($urandom(32'd4099));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R6 reset ce_n", 32'(nand_ce_n), 32'(4'hF));
      chk("R10 reset strobes", {30'b0, nand_we_n, nand_re_n}, 32'h3);
      chk("R1 reset cle/ale", {30'b0, nand_cle, nand_ale}, 32'h0);
      rreg(A_BANK, q); chk("R6 bank reset", q, 32'h1);
      rreg(A_MODE, q); chk("R8 mode reset", q, 32'h0);

      // R8: disabled engine ignores command writes
      n0 = wr_n;
      wreg(A_CMD, 32'h8000_0090); barrier();
      chk("R8 no beat when disabled", 32'(wr_n - n0), 32'h0);
      wreg(A_MODE, 32'h1);

      // R11: timing register readback, random counts including zero
      su = 8'($urandom_range(0, 3)); ho = 8'($urandom_range(0, 3));
      ce = 8'($urandom_range(0, 3)); tw = 8'($urandom_range(0, 3));
      won = 8'($urandom_range(0, 4)); wof = 8'($urandom_range(0, 4));
      ron = 8'($urandom_range(0, 4)); rof = 8'($urandom_range(0, 4));
      won = 8'd0; // directed: zero acts as one
      wreg(A_CTIM, {tw, ce, ho, su}); wreg(A_WTIM, {16'h0, wof, won}); wreg(A_RTIM, {16'h0, rof, ron});
      rreg(A_CTIM, q); chk("R11 control timing", q, {tw, ce, ho, su});
      rreg(A_WTIM, q); chk("R11 write timing", q, {16'h0, wof, won});
      rreg(A_RTIM, q); chk("R11 read timing", q, {16'h0, rof, ron});

      // R1: command beats
      for (int i = 0; i < 4; i++) begin
         b = 8'($urandom); n0 = wr_n;
         wreg(A_CMD, {1'b1, 23'h0, b}); barrier();
         chk("R1 one beat", 32'(wr_n - n0), 32'h1);
         chk("R1 byte", 32'(lg_b[n0 % 256]), 32'(b));
         chk("R1 cle/ale", {30'b0, lg_cle[n0 % 256], lg_ale[n0 % 256]}, 32'h2);
         chk("R5 we low width", 32'(lg_wlow[n0 % 256]), 32'(mx1(won)));
         chk("R9 released", 32'(nand_ce_n), 32'(4'hF));
      end

      // R2: address beats
      b = 8'($urandom); n0 = wr_n;
      wreg(A_ADDR, {2'b11, 22'h0, b}); barrier();
      chk("R2 one beat", 32'(wr_n - n0), 32'h1);
      chk("R2 byte", 32'(lg_b[n0 % 256]), 32'(b));
      chk("R2 cle/ale", {30'b0, lg_cle[n0 % 256], lg_ale[n0 % 256]}, 32'h1);
      n0 = wr_n;
      wreg(A_ADDR, {2'b10, 22'h0, b}); barrier();
      chk("R2 no beat without valid", 32'(wr_n - n0), 32'h0);

      // R3: write data, one and four beats
      wreg(A_WCFG, 32'h8000_0000);
      w = $urandom; n0 = wr_n;
      wreg(A_DATA, w); barrier();
      chk("R3 single beat count", 32'(wr_n - n0), 32'h1);
      chk("R3 single byte", 32'(lg_b[n0 % 256]), 32'(w[7:0]));
      wreg(A_WCFG, 32'h9000_0000);
      gap = mx1(wof) + mx1(ho) + mx1(su);
      for (int i = 0; i < 3; i++) begin
         w = $urandom; n0 = wr_n;
         wreg(A_DATA, w); barrier();
         chk("R3 quad count", 32'(wr_n - n0), 32'h4);
         for (int k = 0; k < 4; k++) begin
            chk("R3 quad lane order", 32'(lg_b[(n0 + k) % 256]), 32'(w[8*k +: 8]));
            if (k > 0) chk("R5 inter-beat gap", 32'(lg_gap[(n0 + k) % 256]), 32'(gap));
         end
      end

      // R4: read data
      wreg(A_RCFG, 32'h8000_0000);
      r0 = rd_n; rreg(A_DATA, q);
      chk("R4 single read", q, {24'h0, rsrc(r0)});
      chk("R5 re low width", 32'(last_rlow), 32'(mx1(ron)));
      wreg(A_RCFG, 32'h9000_0000);
      for (int i = 0; i < 2; i++) begin
         r0 = rd_n; rreg(A_DATA, q);
         exp = {rsrc(r0 + 3), rsrc(r0 + 2), rsrc(r0 + 1), rsrc(r0)};
         chk("R4 quad read", q, exp);
      end

      // R6: bank select
      wreg(A_BANK, 32'h4); rreg(A_BANK, q); chk("R6 bank write", q, 32'h4);
      n0 = wr_n; wreg(A_CMD, 32'h8000_0011); barrier();
      chk("R6 ce during beat", 32'(lg_ce[n0 % 256]), 32'(4'b1011));
      wreg(A_BANK, 32'h3); rreg(A_BANK, q); chk("R6 non-onehot ignored", q, 32'h4);
      wreg(A_BANK, 32'h0); rreg(A_BANK, q); chk("R6 zero ignored", q, 32'h4);

      // R9: CE kept when release clear
      wreg(A_CMD, 32'h0000_0022); barrier();
      chk("R9 ce held", 32'(nand_ce_n), 32'(4'b1011));
      wreg(A_CMD, 32'h8000_0033); barrier();
      chk("R9 ce released", 32'(nand_ce_n), 32'(4'hF));

      // R7: ready/busy status
      nand_rb_n = 1'b0; repeat (4) @(negedge clk);
      rreg(A_STAT, q); chk("R7 busy", q, 32'h0);
      nand_rb_n = 1'b1; repeat (4) @(negedge clk);
      rreg(A_STAT, q); chk("R7 ready", q, 32'h4);

      // R10: stall behind a posted command with long delays
      wreg(A_CTIM, {8'd7, 8'd5, 8'd4, 8'd3}); wreg(A_WTIM, 32'h0000_0602);
      acc(1'b1, A_CMD, 32'h8000_0070, q, lat);
      chk("R10 posted ack", 32'(lat), 32'h1);
      acc(1'b0, A_MODE, 32'h0, q, lat);
      total++;
      if (lat < 3 + 2 + 6 + 4 + 7 + 5 - 1) begin
         bad++;
         $display("FAIL R10 stall latency actual=%0d expected>=%0d", lat, 26);
      end
      chk("R10 strobe/latch exclusivity", 32'(excl_bad), 32'h0);

      // R8: soft reset restores defaults
      wreg(A_BANK, 32'h2);
      wreg(A_MODE, 32'h9); wreg(A_MODE, 32'h1);
      rreg(A_BANK, q); chk("R8 soft reset bank", q, 32'h1);
      rreg(A_CTIM, q); chk("R8 soft reset timing", q, 32'h0);

      summary();
      $finish;
   end
endmodule